// File: doc/BRIEF.md
# Seconds Real-Time Clock with Guarded Start-Up

This block keeps wall-clock time as a 32-bit count of whole seconds. A prescaler advances the count and runs on a slow clock in the 32 kHz range. Software reaches the block through a small register file on a fast bus clock. Each bus write is carried into the slow domain by a toggle handshake. The bus reads from a mirror of the slow-domain registers that is refreshed as a whole, so a multi-bit value is never seen half updated.

After reset the block is held in a start-up state, and timekeeping cannot be trusted there. Software must first load a fixed key into a write-only register. It then issues two control writes in turn: the first leaves the start-up state and the second leaves the untrusted state. Each step sets its own sticky status bit. Once the block is valid and counting is switched on, the counter runs. A one-shot compare against an alarm register sets an alarm flag. That flag drives an interrupt line and, when enabled, a wake request taken straight from the slow domain.

Top module: `lp_rtc_core`

## Requirements
- R1: After reset every readable register returns 0, and `irq`, `wake` and `wr_busy` are low.
- R2: A control write leaves a start-up state only while the key register (offset 0x18) holds 0x41736166. The key register always reads as 0, and loading it alone changes no status bit.
- R3: In the start-up state, with the key loaded, a control write (offset 0x10) that has bits 15 and 11 set moves the block to the untrusted state and sets status bit 15.
- R4: In the untrusted state, with the key loaded, a control write that has bits 15, 14, 11 and 3 set makes the block valid and sets status bit 14. The valid state is reached only through the untrusted state.
- R5: The status register (offset 0x14) is write-one-to-clear: each 1 written clears that bit and each 0 leaves it as it was.
- R6: Counting happens only when the block is valid and control bit 3 is set. The prescaler (offset 0x04, width PRE_W, read-only) then steps once per slow clock, and the seconds counter (offset 0x00) steps when the prescaler rolls over from all-ones to 0.
- R7: A write to the seconds register loads it and clears the prescaler. The seconds counter wraps from 0xFFFFFFFF to 0.
- R8: When the seconds counter steps to a value equal to the alarm register (offset 0x08), status bit 3 is set. A set in the same cycle as a clear of that bit takes priority.
- R9: `irq` is high while status bit 3 and control bit 7 are both set. `wake` is high while `irq`'s condition holds and control bit 4 is also set.
- R10: `wr_busy` rises in the cycle after a write is accepted and falls once the slow domain has applied it. A write presented while `wr_busy` is high is dropped. A write takes effect by the third slow-clock edge.
- R11: Reads return the latest complete mirror of the slow registers. Control reads back only bits 15, 14, 11, 7, 4 and 3. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset, bus domain |
| slow_clk | input | 1 | Slow timekeeping clock |
| slow_rst | input | 1 | Synchronous active-high reset, slow domain |
| bus_wr_en | input | 1 | Write strobe, one bus cycle |
| bus_addr | input | 5 | Byte offset of the register to write or read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for `bus_addr` |
| wr_busy | output | 1 | A write is still crossing into the slow domain |
| irq | output | 1 | Alarm interrupt, synchronised to the bus clock |
| wake | output | 1 | Wake request, slow-clock domain |

## Verification
A write reaches the slow registers two or three slow edges after it is accepted. `wr_busy` falls a few bus cycles after that. A read result arrives two bus cycles after the address is set, but it reflects the slow state only after a full mirror refresh of about three slow cycles. Every bench write therefore waits for `wr_busy` to fall and then for eight further slow edges before it reads back. Results that depend on counting are taken only after counting has been stopped, or are checked against a window wide enough for the few slow cycles that each crossing adds.

// File: rtl/lp_rtc_pkg.sv
package lp_rtc_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFF_SEC  = 5'h00;
  localparam logic [ADDR_W-1:0] OFF_FRAC = 5'h04;
  localparam logic [ADDR_W-1:0] OFF_ALM  = 5'h08;
  localparam logic [ADDR_W-1:0] OFF_CTRL = 5'h10;
  localparam logic [ADDR_W-1:0] OFF_STAT = 5'h14;
  localparam logic [ADDR_W-1:0] OFF_KEY  = 5'h18;

  // control bit positions
  localparam int CB_RUN  = 3;
  localparam int CB_WAKE = 4;
  localparam int CB_AIE  = 7;
  localparam int CB_NSA  = 11;
  localparam int CB_NVX  = 14;
  localparam int CB_INX  = 15;
  // status bit positions
  localparam int SB_ALM  = 3;
  localparam int SB_NVD  = 14;
  localparam int SB_IND  = 15;

  localparam logic [DATA_W-1:0] CTRL_MASK = (DATA_W'(1) << CB_RUN) | (DATA_W'(1) << CB_WAKE) |
                                            (DATA_W'(1) << CB_AIE) | (DATA_W'(1) << CB_NSA) |
                                            (DATA_W'(1) << CB_NVX) | (DATA_W'(1) << CB_INX);
  localparam logic [DATA_W-1:0] STAT_MASK = (DATA_W'(1) << SB_ALM) | (DATA_W'(1) << SB_NVD) |
                                            (DATA_W'(1) << SB_IND);
  localparam logic [DATA_W-1:0] START_KEY = 32'h4173_6166;

  typedef enum logic [1:0] {
    ST_INIT     = 2'd0,
    ST_NONVALID = 2'd1,
    ST_VALID    = 2'd2
  } rtc_state_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } wr_req_t;

  typedef struct packed {
    logic [DATA_W-1:0] sec;
    logic [DATA_W-1:0] frac;
    logic [DATA_W-1:0] alarm;
    logic [DATA_W-1:0] ctrl;
    logic [DATA_W-1:0] stat;
  } rtc_view_t;
endpackage

// File: rtl/lp_rtc_wr_cdc.sv
module lp_rtc_wr_cdc
  import lp_rtc_pkg::*;
#(
  parameter int SYNC_N = 2
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    wr_en,
  input  wr_req_t wr_in,
  output logic    busy,
  input  logic    slow_clk,
  input  logic    slow_rst,
  output logic    apply,
  output wr_req_t req_out
);
  logic              req_tgl;
  wr_req_t           hold;
  logic [SYNC_N-1:0] ack_sync;
  logic [SYNC_N-1:0] req_sync;
  logic              req_seen;

  assign busy    = req_tgl ^ ack_sync[SYNC_N-1];
  assign req_out = hold;

  // bus side: capture and toggle
  always_ff @(posedge clk) begin
    if (rst) begin
      req_tgl <= 1'b0;
      hold    <= '0;
    end else if (wr_en && !busy) begin
      hold    <= wr_in;
      req_tgl <= ~req_tgl;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ack_sync <= '0;
    else     ack_sync <= {ack_sync[SYNC_N-2:0], req_seen};
  end

  // slow side: detect toggle, req_seen doubles as the acknowledge
  always_ff @(posedge slow_clk) begin
    if (slow_rst) begin
      req_sync <= '0;
      req_seen <= 1'b0;
    end else begin
      req_sync <= {req_sync[SYNC_N-2:0], req_tgl};
      req_seen <= req_sync[SYNC_N-1];
    end
  end

  assign apply = req_sync[SYNC_N-1] ^ req_seen;

  p_busy_after_accept_r10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !busy) |=> busy);

  p_apply_single_r10: assert property (@(posedge slow_clk) disable iff (slow_rst)
    apply |=> !apply);
endmodule

// File: rtl/lp_rtc_slow_core.sv
module lp_rtc_slow_core
  import lp_rtc_pkg::*;
#(
  parameter int PRE_W = 15
) (
  input  logic              slow_clk,
  input  logic              slow_rst,
  input  logic              apply,
  input  wr_req_t           req,
  output logic [DATA_W-1:0] seconds_q,
  output logic [PRE_W-1:0]  pre_q,
  output logic [DATA_W-1:0] alarm_q,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] stat_q,
  output logic              irq_q,
  output logic              wake_q
);
  rtc_state_e        state_q, state_d;
  logic [DATA_W-1:0] key_q, key_d;
  logic [DATA_W-1:0] sec_d, alm_d, ctrl_d, stat_d, stat_set, stat_clr;
  logic [PRE_W-1:0]  pre_d;
  logic              key_ok, counting, pre_wrap, sec_inc;

  assign key_ok   = (key_q == START_KEY);
  assign counting = (state_q == ST_VALID) && ctrl_q[CB_RUN];
  assign pre_wrap = &pre_q;
  assign sec_inc  = counting && pre_wrap;

  always_comb begin
    sec_d    = seconds_q;
    pre_d    = pre_q;
    alm_d    = alarm_q;
    ctrl_d   = ctrl_q;
    key_d    = key_q;
    state_d  = state_q;
    stat_set = '0;
    stat_clr = '0;
    if (counting) begin
      pre_d = pre_q + 1'b1;
      if (pre_wrap) sec_d = seconds_q + 32'd1;
    end
    if (sec_inc && ((seconds_q + 32'd1) == alarm_q)) stat_set[SB_ALM] = 1'b1;
    if (apply) begin
      case (req.addr)
        OFF_SEC: begin
          sec_d = req.data;
          pre_d = '0;
        end
        OFF_ALM:  alm_d = req.data;
        OFF_CTRL: begin
          ctrl_d = req.data & CTRL_MASK;
          if (key_ok) begin
            if (state_q == ST_INIT && req.data[CB_INX] && req.data[CB_NSA]) begin
              state_d          = ST_NONVALID;
              stat_set[SB_IND] = 1'b1;
            end else if (state_q == ST_NONVALID && req.data[CB_INX] && req.data[CB_NVX] &&
                         req.data[CB_NSA] && req.data[CB_RUN]) begin
              state_d          = ST_VALID;
              stat_set[SB_NVD] = 1'b1;
            end
          end
        end
        OFF_STAT: stat_clr = req.data & STAT_MASK;
        OFF_KEY:  key_d = req.data;
        default:  ;
      endcase
    end
    stat_d = (stat_q & ~stat_clr) | stat_set;
  end

  always_ff @(posedge slow_clk) begin
    if (slow_rst) begin
      seconds_q <= '0;
      pre_q     <= '0;
      alarm_q   <= '0;
      ctrl_q    <= '0;
      stat_q    <= '0;
      key_q     <= '0;
      state_q   <= ST_INIT;
      irq_q     <= 1'b0;
      wake_q    <= 1'b0;
    end else begin
      seconds_q <= sec_d;
      pre_q     <= pre_d;
      alarm_q   <= alm_d;
      ctrl_q    <= ctrl_d;
      stat_q    <= stat_d;
      key_q     <= key_d;
      state_q   <= state_d;
      irq_q     <= stat_d[SB_ALM] & ctrl_d[CB_AIE];
      wake_q    <= stat_d[SB_ALM] & ctrl_d[CB_AIE] & ctrl_d[CB_WAKE];
    end
  end

  p_exit_needs_key_r2: assert property (@(posedge slow_clk) disable iff (slow_rst)
    (state_q != ST_INIT && $past(state_q) == ST_INIT) |-> $past(key_ok));

  p_valid_via_nonvalid_r4: assert property (@(posedge slow_clk) disable iff (slow_rst)
    (state_q == ST_VALID && $past(state_q) != ST_VALID) |-> $past(state_q) == ST_NONVALID);

  p_frozen_unless_counting_r6: assert property (@(posedge slow_clk) disable iff (slow_rst)
    (!counting && !apply) |=> ($stable(seconds_q) && $stable(pre_q)));

  p_flag_on_match_r8: assert property (@(posedge slow_clk) disable iff (slow_rst)
    $rose(stat_q[SB_ALM]) |-> ((seconds_q == alarm_q) || $past(apply)));

  p_wake_implies_irq_r9: assert property (@(posedge slow_clk) disable iff (slow_rst)
    wake_q |-> irq_q);
endmodule

// File: rtl/lp_rtc_snap.sv
module lp_rtc_snap
  import lp_rtc_pkg::*;
#(
  parameter int SYNC_N = 2
) (
  input  logic      slow_clk,
  input  logic      slow_rst,
  input  rtc_view_t live,
  input  logic      clk,
  input  logic      rst,
  output rtc_view_t mirror
);
  rtc_view_t         hold;
  logic              tgl_s;
  logic [SYNC_N-1:0] ack_sync;
  logic [SYNC_N-1:0] tgl_sync;
  logic              seen;
  logic              pending;

  assign pending = tgl_s ^ ack_sync[SYNC_N-1];

  // slow side: refresh the holding copy only once the last one was taken
  always_ff @(posedge slow_clk) begin
    if (slow_rst) begin
      hold     <= '0;
      tgl_s    <= 1'b0;
      ack_sync <= '0;
    end else begin
      ack_sync <= {ack_sync[SYNC_N-2:0], seen};
      if (!pending) begin
        hold  <= live;
        tgl_s <= ~tgl_s;
      end
    end
  end

  // bus side: copy the whole view on a toggle edge
  always_ff @(posedge clk) begin
    if (rst) begin
      tgl_sync <= '0;
      seen     <= 1'b0;
      mirror   <= '0;
    end else begin
      tgl_sync <= {tgl_sync[SYNC_N-2:0], tgl_s};
      seen     <= tgl_sync[SYNC_N-1];
      if (tgl_sync[SYNC_N-1] ^ seen) mirror <= hold;
    end
  end

  p_hold_stable_pending_r11: assert property (@(posedge slow_clk) disable iff (slow_rst)
    pending |=> $stable(hold));
endmodule

// File: rtl/lp_rtc_core.sv
module lp_rtc_core
  import lp_rtc_pkg::*;
#(
  parameter int PRE_W  = 15,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slow_clk,
  input  logic              slow_rst,
  input  logic              bus_wr_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              wr_busy,
  output logic              irq,
  output logic              wake
);
  localparam int PAD_W = DATA_W - PRE_W;

  wr_req_t           req;
  logic              apply;
  logic [DATA_W-1:0] seconds, alarm, ctrl, stat;
  logic [PRE_W-1:0]  pre;
  logic              irq_s;
  logic [SYNC_N-1:0] irq_sync;
  rtc_view_t         live, mirror;

  lp_rtc_wr_cdc #(.SYNC_N(SYNC_N)) u_wr_cdc (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (bus_wr_en),
    .wr_in    ('{addr: bus_addr, data: bus_wdata}),
    .busy     (wr_busy),
    .slow_clk (slow_clk),
    .slow_rst (slow_rst),
    .apply    (apply),
    .req_out  (req)
  );

  lp_rtc_slow_core #(.PRE_W(PRE_W)) u_core (
    .slow_clk  (slow_clk),
    .slow_rst  (slow_rst),
    .apply     (apply),
    .req       (req),
    .seconds_q (seconds),
    .pre_q     (pre),
    .alarm_q   (alarm),
    .ctrl_q    (ctrl),
    .stat_q    (stat),
    .irq_q     (irq_s),
    .wake_q    (wake)
  );

  assign live = '{sec: seconds, frac: {{PAD_W{1'b0}}, pre}, alarm: alarm, ctrl: ctrl, stat: stat};

  lp_rtc_snap #(.SYNC_N(SYNC_N)) u_snap (
    .slow_clk (slow_clk),
    .slow_rst (slow_rst),
    .live     (live),
    .clk      (clk),
    .rst      (rst),
    .mirror   (mirror)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_sync <= '0;
    else     irq_sync <= {irq_sync[SYNC_N-2:0], irq_s};
  end
  assign irq = irq_sync[SYNC_N-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      case (bus_addr)
        OFF_SEC:  bus_rdata <= mirror.sec;
        OFF_FRAC: bus_rdata <= mirror.frac;
        OFF_ALM:  bus_rdata <= mirror.alarm;
        OFF_CTRL: bus_rdata <= mirror.ctrl;
        OFF_STAT: bus_rdata <= mirror.stat;
        default:  bus_rdata <= '0;
      endcase
    end
  end

  p_ctrl_view_masked_r11: assert property (@(posedge clk) disable iff (rst)
    (mirror.ctrl & ~CTRL_MASK) == '0);
endmodule

// File: tb/lp_rtc_core_tb.sv
module lp_rtc_core_tb;
  import lp_rtc_pkg::*;

  logic        clk = 1'b0, slow_clk = 1'b0;
  logic        rst = 1'b1, slow_rst = 1'b1;
  logic        bus_wr_en = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wr_busy, irq, wake;
  int          n_tests = 0, n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;
  always #33 slow_clk = ~slow_clk;

  lp_rtc_core #(.PRE_W(3), .SYNC_N(2)) u_dut (
    .clk(clk), .rst(rst), .slow_clk(slow_clk), .slow_rst(slow_rst),
    .bus_wr_en(bus_wr_en), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .wr_busy(wr_busy), .irq(irq), .wake(wake)
  );

  typedef struct packed {
    logic [4:0]  waddr;
    logic [31:0] wdata;
    logic [4:0]  raddr;
    logic [31:0] exp;
    logic [3:0]  tag;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{5'h08, 32'h0000_1234, 5'h08, 32'h0000_1234, 4'd11}, // R11 alarm readback
    '{5'h10, 32'hFFFF_FFFF, 5'h10, 32'h0000_C898, 4'd11}, // R11 control mask
    '{5'h10, 32'hFFFF_FFFF, 5'h14, 32'h0000_0000, 4'd2},  // R2 no key, no exit
    '{5'h18, 32'h1234_5678, 5'h18, 32'h0000_0000, 4'd2},  // R2 key reads 0
    '{5'h10, 32'h0000_8800, 5'h14, 32'h0000_0000, 4'd2},  // R2 wrong key
    '{5'h04, 32'h0000_7777, 5'h04, 32'h0000_0000, 4'd6},  // R6 prescaler read-only
    '{5'h18, 32'h4173_6166, 5'h14, 32'h0000_0000, 4'd2},  // R2 key alone
    '{5'h10, 32'h0000_8800, 5'h14, 32'h0000_8000, 4'd3},  // R3 init exit
    '{5'h10, 32'h0000_C808, 5'h14, 32'h0000_C000, 4'd4},  // R4 non-valid exit
    '{5'h14, 32'h0000_8000, 5'h14, 32'h0000_4000, 4'd5},  // R5 clear one bit
    '{5'h14, 32'h0000_0000, 5'h14, 32'h0000_4000, 4'd5},  // R5 zeros keep
    '{5'h10, 32'h0000_C890, 5'h10, 32'h0000_C890, 4'd6},  // R6 counting off
    '{5'h00, 32'hFFFF_FFFF, 5'h00, 32'hFFFF_FFFF, 4'd7},  // R7 load seconds
    '{5'h00, 32'hFFFF_FFFF, 5'h04, 32'h0000_0000, 4'd7}   // R7 prescaler cleared
  };

  task automatic check(input int tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge slow_clk);
    @(negedge clk);
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    while (wr_busy) @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr_en = 1'b1;
    @(negedge clk);
    bus_wr_en = 1'b0;
    while (wr_busy) @(negedge clk);
    settle(8);
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    @(negedge clk);
    d = bus_rdata;
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL R10 watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, rd2;
    repeat (5) @(posedge slow_clk);
    @(negedge clk);
    rst = 1'b0;
    slow_rst = 1'b0;
    settle(8);

    // R1 reset state
    bus_read(5'h00, rd); check(1, rd, 32'h0);
    bus_read(5'h04, rd); check(1, rd, 32'h0);
    bus_read(5'h10, rd); check(1, rd, 32'h0);
    bus_read(5'h14, rd); check(1, rd, 32'h0);
    check(1, {29'b0, irq, wake, wr_busy}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      bus_write(VECS[i].waddr, VECS[i].wdata);
      bus_read(VECS[i].raddr, rd);
      check(int'(VECS[i].tag), rd, VECS[i].exp);
    end

    // R6 frozen while control bit 3 is clear
    bus_read(5'h04, rd);
    settle(5);
    bus_read(5'h04, rd2);
    check(6, rd2, rd);

    // R7 / R8 wrap to 0 with alarm at 0, then stop counting
    bus_write(5'h08, 32'h0);
    bus_write(5'h10, 32'h0000_C898);
    bus_write(5'h10, 32'h0000_C890);
    bus_read(5'h00, rd); check(7, rd, 32'h0);
    bus_read(5'h14, rd); check(8, rd, 32'h0000_4008);
    check(9, {30'b0, irq, wake}, 32'h3); // R9 both enabled

    // R9 masking by control bits 7 and 4
    bus_write(5'h10, 32'h0000_C880);
    check(9, {30'b0, irq, wake}, 32'h2);
    bus_write(5'h10, 32'h0000_C800);
    check(9, {30'b0, irq, wake}, 32'h0);
    bus_write(5'h10, 32'h0000_C880);
    check(9, {30'b0, irq, wake}, 32'h2);
    // R5 clear alarm flag, irq drops
    bus_write(5'h14, 32'h0000_0008);
    bus_read(5'h14, rd); check(5, rd, 32'h0000_4000);
    check(9, {31'b0, irq}, 32'h0);

    // R10 second write while busy is dropped
    @(negedge clk);
    bus_addr = 5'h08; bus_wdata = 32'h0000_AAAA; bus_wr_en = 1'b1;
    @(negedge clk);
    check(10, {31'b0, wr_busy}, 32'h1);
    bus_wdata = 32'h0000_5555;
    @(negedge clk);
    bus_wr_en = 1'b0;
    while (wr_busy) @(negedge clk);
    settle(8);
    bus_read(5'h08, rd); check(10, rd, 32'h0000_AAAA);

    // R6 seconds advance about once per 8 slow cycles
    bus_write(5'h00, 32'h0000_0100);
    bus_write(5'h10, 32'h0000_C808);
    bus_read(5'h00, rd);
    settle(40);
    bus_read(5'h00, rd2);
    check(6, {31'b0, (rd2 - rd >= 32'd4) && (rd2 - rd <= 32'd6)}, 32'h1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule